// File: doc/BRIEF.md
# Row Migration Decision Unit

This block belongs in a hybrid memory controller. A small, fast memory acts there as a cache in front of a large, slow memory, and this block chooses which rows of the slow memory should be copied into the fast one. Each request gives a byte address and a flag. The flag says whether the access missed the slow memory's open row buffer. The address is reduced to a 2 KB row number. For each row, a set-associative statistics table holds two saturating counts: how often the row was touched, and how often those touches missed the row buffer.

A row is promoted only when both counts reach their programmable thresholds in the same quantum. Frequent reuse alone does not promote a row, and neither do frequent row buffer misses alone. When a row is promoted, the unit pulses a strobe that carries the row number and drops the row's entry. A free-running quantum timer wipes the whole table at the end of each quantum, so the statistics always describe recent behaviour. The unit also reports how many entries are occupied and marks the last cycle of each quantum.

Top module: `row_migrate_unit`

## Requirements
- R1: The row number is the request address shifted right by log2(ROW_BYTES), which is 11 for 2 KB rows. Two byte addresses that differ only in those low bits update the same entry, and `mig_row` carries the row number.
- R2: A request that finds its row in the table adds one to that row's access count. It adds one to the miss count only when `req_rb_miss` is 1. A row that is not in the table gets a fresh entry holding one access, and one miss if `req_rb_miss` is 1, otherwise zero misses.
- R3: `mig_valid` is high for exactly the one cycle after an accepted request whose updated counts meet access >= `acc_thresh` and miss >= `miss_thresh`. In that cycle `mig_row` equals that request's row. In every other cycle `mig_valid` is low.
- R4: While `miss_thresh` is at least 1, a row whose requests all hit the row buffer never raises `mig_valid`, however many accesses it receives.
- R5: `q_tick` is high in the last cycle of every QUANTUM-cycle period, counted from reset release. At the end of that cycle all entries are cleared. A request accepted in that same cycle is counted after the clear, as a fresh entry.
- R6: The table has ENTRIES/WAYS sets of WAYS ways. The set index is the low log2(ENTRIES/WAYS) bits of the row number. A new row takes the lowest-numbered empty way of its set. If the set has no empty way, the new row takes the least recently used way.
- R7: Both counts stop at 2^CNT_W-1 and do not wrap.
- R8: Once a row has been promoted, its entry is removed. The next request to that row starts a fresh entry.
- R9: `occ_count` equals the number of valid entries after each cycle's update.
- R10: `req_ready` is high in every cycle after the first clock edge following reset release, so one request can be accepted each cycle.
- R11: While reset is held, `mig_valid` is 0, `occ_count` is 0, `req_ready` is 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_thresh | input | CNT_W | Access count needed for promotion |
| miss_thresh | input | CNT_W | Row buffer miss count needed for promotion |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_rb_miss | input | 1 | Request missed the slow memory row buffer |
| mig_valid | output | 1 | One-cycle promotion strobe |
| mig_row | output | ADDR_W-log2(ROW_BYTES) | Row number to promote |
| occ_count | output | log2(ENTRIES+1) | Number of valid table entries |
| q_tick | output | 1 | Last cycle of the current quantum |

## Verification
The checker assumes that requests arrive only through the valid/ready pair. It also assumes that QUANTUM is at least two cycles, which means two quantum ticks never fall in back-to-back cycles. The stimulus drives `req_valid` low while reset is held. It changes the inputs only well away from the clock edge. It uses only QUANTUM and threshold values that fit the counter widths, including thresholds equal to the saturated count value.

// File: rtl/rmd_pkg.sv
package rmd_pkg;
   // How the selected way of a set is being used by the current request.
   typedef enum logic [1:0] {
      FILL_HIT   = 2'd0,
      FILL_EMPTY = 2'd1,
      FILL_EVICT = 2'd2
   } rmd_fill_e;
endpackage

// File: rtl/rmd_quantum_timer.sv
module rmd_quantum_timer #(
   parameter int QUANTUM = 4096
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int QW = (QUANTUM > 1) ? $clog2(QUANTUM) : 1;
   localparam logic [QW-1:0] LAST = QW'(QUANTUM - 1);

   logic [QW-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + QW'(1);
      end
   end
endmodule

// File: rtl/rmd_way_pick.sv
module rmd_way_pick
   import rmd_pkg::*;
#(
   parameter int WAYS  = 8,
   parameter int TAG_W = 16,
   parameter int WAY_W = 3
) (
   input  logic [WAYS-1:0]       live,
   input  logic [WAYS*TAG_W-1:0] tags,
   input  logic [WAYS*WAY_W-1:0] ages,
   input  logic [TAG_W-1:0]      tag,
   output logic [WAY_W-1:0]      way,
   output rmd_fill_e             fill
);
   logic [WAYS-1:0] hit_vec;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = live[w] && (tags[w*TAG_W +: TAG_W] == tag);
   end

   // Priority: matching way, then lowest empty way, then oldest way.
   always_comb begin
      way  = '0;
      fill = FILL_EVICT;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (ages[w*WAY_W +: WAY_W] == WAY_W'(WAYS - 1)) way = WAY_W'(w);
      end
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!live[w]) begin
            way  = WAY_W'(w);
            fill = FILL_EMPTY;
         end
      end
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w]) begin
            way  = WAY_W'(w);
            fill = FILL_HIT;
         end
      end
   end
endmodule

// File: rtl/rmd_stat_update.sv
module rmd_stat_update #(
   parameter int CNT_W = 4
) (
   input  logic             hit,
   input  logic             rb_miss,
   input  logic [CNT_W-1:0] acc_old,
   input  logic [CNT_W-1:0] miss_old,
   input  logic [CNT_W-1:0] acc_thr,
   input  logic [CNT_W-1:0] miss_thr,
   output logic [CNT_W-1:0] acc_new,
   output logic [CNT_W-1:0] miss_new,
   output logic             promote
);
   logic [CNT_W-1:0] acc_base;
   logic [CNT_W-1:0] miss_base;

   // A fresh entry starts from zero before this request is counted.
   assign acc_base  = hit ? acc_old  : '0;
   assign miss_base = hit ? miss_old : '0;

   assign acc_new  = (&acc_base) ? acc_base : acc_base + CNT_W'(1);
   assign miss_new = (!rb_miss || (&miss_base)) ? miss_base : miss_base + CNT_W'(1);
   assign promote  = (acc_new >= acc_thr) && (miss_new >= miss_thr);
endmodule

// File: rtl/row_migrate_unit.sv
module row_migrate_unit
   import rmd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int ROW_BYTES = 2048,
   parameter int ENTRIES   = 512,
   parameter int WAYS      = 8,
   parameter int CNT_W     = 4,
   parameter int QUANTUM   = 4096
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic [CNT_W-1:0]                      acc_thresh,
   input  logic [CNT_W-1:0]                      miss_thresh,
   input  logic                                  req_valid,
   output logic                                  req_ready,
   input  logic [ADDR_W-1:0]                     req_addr,
   input  logic                                  req_rb_miss,
   output logic                                  mig_valid,
   output logic [ADDR_W-$clog2(ROW_BYTES)-1:0]   mig_row,
   output logic [$clog2(ENTRIES+1)-1:0]          occ_count,
   output logic                                  q_tick
);
   localparam int ROW_SHIFT = $clog2(ROW_BYTES);
   localparam int ROW_W     = ADDR_W - ROW_SHIFT;
   localparam int SETS      = ENTRIES / WAYS;
   localparam int IDX_W     = $clog2(SETS);
   localparam int TAG_W     = ROW_W - IDX_W;
   localparam int WAY_W     = $clog2(WAYS);
   localparam int OCC_W     = $clog2(ENTRIES + 1);
   localparam logic [OCC_W-1:0] OCC_ONE  = OCC_W'(1);
   localparam logic [OCC_W-1:0] OCC_ZERO = '0;

   // Elaboration-time configuration checks.
   if (ENTRIES < 512 || ENTRIES > 4096) begin : g_bad_entries
      $error("row_migrate_unit: ENTRIES must lie in 512..4096");
   end
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("row_migrate_unit: WAYS must be a power of two, at least 2");
   end
   if ((SETS * WAYS) != ENTRIES || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("row_migrate_unit: ENTRIES/WAYS must be a power of two");
   end
   if ((1 << ROW_SHIFT) != ROW_BYTES || TAG_W < 1) begin : g_bad_row
      $error("row_migrate_unit: ROW_BYTES must be a power of two below the address space");
   end
   if (QUANTUM < 2 || CNT_W < 1) begin : g_bad_misc
      $error("row_migrate_unit: QUANTUM must be at least 2 and CNT_W at least 1");
   end

   // Table storage.
   logic [WAYS-1:0]  valid_q [SETS];
   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic [CNT_W-1:0] acc_q   [SETS][WAYS];
   logic [CNT_W-1:0] miss_q  [SETS][WAYS];
   logic [WAY_W-1:0] age_q   [SETS][WAYS];
   logic             ready_q;

   // Request decode.
   logic             accept;
   logic [ROW_W-1:0] row;
   logic [IDX_W-1:0] set_idx;
   logic [TAG_W-1:0] row_tag;
   logic             unused_low;

   assign req_ready  = ready_q;
   assign accept     = req_valid && ready_q;
   assign row        = req_addr[ADDR_W-1:ROW_SHIFT];
   assign set_idx    = row[IDX_W-1:0];
   assign row_tag    = row[ROW_W-1:IDX_W];
   assign unused_low = ^req_addr[ROW_SHIFT-1:0];

   rmd_quantum_timer #(.QUANTUM(QUANTUM)) timer_i (
      .clk  (clk),
      .rst  (rst),
      .tick (q_tick)
   );

   // Set read-out; a quantum boundary hides every entry from this request.
   logic [WAYS-1:0]       live;
   logic [WAYS*TAG_W-1:0] set_tags;
   logic [WAYS*WAY_W-1:0] set_ages;

   assign live = q_tick ? '0 : valid_q[set_idx];

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         set_tags[w*TAG_W +: TAG_W] = tag_q[set_idx][w];
         set_ages[w*WAY_W +: WAY_W] = age_q[set_idx][w];
      end
   end

   logic [WAY_W-1:0] pick_way;
   rmd_fill_e        fill;

   rmd_way_pick #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) pick_i (
      .live (live),
      .tags (set_tags),
      .ages (set_ages),
      .tag  (row_tag),
      .way  (pick_way),
      .fill (fill)
   );

   logic [CNT_W-1:0] acc_new;
   logic [CNT_W-1:0] miss_new;
   logic             promote;

   rmd_stat_update #(.CNT_W(CNT_W)) stat_i (
      .hit      (fill == FILL_HIT),
      .rb_miss  (req_rb_miss),
      .acc_old  (acc_q[set_idx][pick_way]),
      .miss_old (miss_q[set_idx][pick_way]),
      .acc_thr  (acc_thresh),
      .miss_thr (miss_thresh),
      .acc_new  (acc_new),
      .miss_new (miss_new),
      .promote  (promote)
   );

   // Occupancy: drop the way's former entry if it was live, add it back unless promoted.
   logic             was_live;
   logic [OCC_W-1:0] occ_base;
   logic [OCC_W-1:0] occ_next;
   logic [WAY_W-1:0] old_age;

   assign was_live = (fill != FILL_EMPTY);
   assign occ_base = q_tick ? OCC_ZERO : occ_count;
   assign occ_next = accept ? (occ_base - (was_live ? OCC_ONE : OCC_ZERO)
                                        + (promote ? OCC_ZERO : OCC_ONE))
                            : occ_base;
   assign old_age  = age_q[set_idx][pick_way];

   always_ff @(posedge clk) begin
      if (rst) begin
         ready_q   <= 1'b0;
         mig_valid <= 1'b0;
         mig_row   <= '0;
         occ_count <= '0;
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
         end
      end else begin
         ready_q   <= 1'b1;
         mig_valid <= accept && promote;
         occ_count <= occ_next;
         if (accept && promote) mig_row <= row;
         if (q_tick) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
         end
         if (accept) begin
            valid_q[set_idx][pick_way] <= !promote;
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_W'(w) == pick_way) begin
                  age_q[set_idx][w] <= '0;
               end else if (age_q[set_idx][w] < old_age) begin
                  age_q[set_idx][w] <= age_q[set_idx][w] + WAY_W'(1);
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         tag_q[set_idx][pick_way]  <= row_tag;
         acc_q[set_idx][pick_way]  <= acc_new;
         miss_q[set_idx][pick_way] <= miss_new;
      end
   end
endmodule

// File: rtl/rmd_checker.sv
module rmd_checker #(
   parameter int ADDR_W    = 32,
   parameter int ROW_BYTES = 2048,
   parameter int ENTRIES   = 512
) (
   input logic                                clk,
   input logic                                rst,
   input logic                                req_valid,
   input logic                                req_ready,
   input logic [ADDR_W-1:0]                   req_addr,
   input logic                                mig_valid,
   input logic [ADDR_W-$clog2(ROW_BYTES)-1:0] mig_row,
   input logic [$clog2(ENTRIES+1)-1:0]        occ_count,
   input logic                                q_tick
);
   localparam int ROW_SHIFT = $clog2(ROW_BYTES);
   localparam int OCC_W     = $clog2(ENTRIES + 1);
   localparam logic [OCC_W-1:0] ONE   = OCC_W'(1);
   localparam logic [OCC_W-1:0] LIMIT = OCC_W'(ENTRIES);

   // R10
   ready_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> req_ready);

   // R3
   mig_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
      mig_valid |-> $past(req_valid && req_ready));

   // R1
   mig_row_match_chk: assert property (@(posedge clk) disable iff (rst)
      mig_valid |-> (mig_row == $past(req_addr[ADDR_W-1:ROW_SHIFT])));

   // R9
   occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
      occ_count <= LIMIT);

   // R9
   occ_step_chk: assert property (@(posedge clk) disable iff (rst)
      !q_tick |=> ((occ_count == $past(occ_count)) ||
                   (occ_count == $past(occ_count) + ONE) ||
                   (occ_count + ONE == $past(occ_count))));

   // R5
   quantum_clear_chk: assert property (@(posedge clk) disable iff (rst)
      q_tick |=> (occ_count <= ONE));

   // R5
   tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      q_tick |=> !q_tick);
endmodule

bind row_migrate_unit rmd_checker #(
   .ADDR_W    (ADDR_W),
   .ROW_BYTES (ROW_BYTES),
   .ENTRIES   (ENTRIES)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .mig_valid (mig_valid),
   .mig_row   (mig_row),
   .occ_count (occ_count),
   .q_tick    (q_tick)
);

// File: tb/row_migrate_unit_tb_top.sv
`timescale 1ns/1ps
module row_migrate_unit_tb_top;
   localparam int ADDR_W = 32;
   localparam int ROW_BYTES = 2048;
   localparam int ENTRIES = 512;
   localparam int WAYS = 8;
   localparam int CNT_W = 3;
   localparam int QUANTUM = 200;
   localparam int SETS = ENTRIES / WAYS;
   localparam int CMAX = (1 << CNT_W) - 1;
   localparam int SHIFT = 11;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst = 1'b1;
   logic [CNT_W-1:0] acc_thresh = '0;
   logic [CNT_W-1:0] miss_thresh = '0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [ADDR_W-1:0] req_addr = '0;
   logic req_rb_miss = 1'b0;
   logic mig_valid;
   logic [ADDR_W-SHIFT-1:0] mig_row;
   logic [$clog2(ENTRIES+1)-1:0] occ_count;
   logic q_tick;

   row_migrate_unit #(
      .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .ENTRIES(ENTRIES),
      .WAYS(WAYS), .CNT_W(CNT_W), .QUANTUM(QUANTUM)
   ) dut_i (
      .clk(clk), .rst(rst), .acc_thresh(acc_thresh), .miss_thresh(miss_thresh),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_rb_miss(req_rb_miss), .mig_valid(mig_valid), .mig_row(mig_row),
      .occ_count(occ_count), .q_tick(q_tick)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   string tag = "R11";

   // Behavioural reference: per-set recency lists with the newest way first.
   int m_tag [SETS][WAYS];
   int m_acc [SETS][WAYS];
   int m_miss[SETS][WAYS];
   bit m_val [SETS][WAYS];
   int m_ord [SETS][WAYS];
   int m_q, m_occ, m_row;
   bit m_ready, m_mig;

   task automatic model_reset();
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            m_val[s][w] = 1'b0;
            m_ord[s][w] = w;
         end
      m_q = 0; m_occ = 0; m_ready = 1'b0; m_mig = 1'b0; m_row = 0;
   endtask

   task automatic touch(int s, int w);
      int p = 0;
      for (int i = 0; i < WAYS; i++) if (m_ord[s][i] == w) p = i;
      for (int i = p; i > 0; i--) m_ord[s][i] = m_ord[s][i-1];
      m_ord[s][0] = w;
   endtask

   task automatic model_step();
      bit tick, acc_ok, hit, prom;
      int row, s, t, way, a, m;
      if (rst) begin
         model_reset();
         return;
      end
      tick = (m_q == QUANTUM - 1);
      acc_ok = req_valid && m_ready;
      if (tick) begin
         for (int i = 0; i < SETS; i++)
            for (int w = 0; w < WAYS; w++) m_val[i][w] = 1'b0;
         m_occ = 0;
      end
      m_mig = 1'b0;
      if (acc_ok) begin
         row = int'(req_addr >> SHIFT);
         s = row % SETS;
         t = row / SETS;
         hit = 1'b0; way = -1;
         for (int w = 0; w < WAYS; w++)
            if (!hit && m_val[s][w] && m_tag[s][w] == t) begin hit = 1'b1; way = w; end
         if (!hit)
            for (int w = 0; w < WAYS; w++) if (way < 0 && !m_val[s][w]) way = w;
         if (way < 0) way = m_ord[s][WAYS-1];
         a = hit ? m_acc[s][way] : 0;
         m = hit ? m_miss[s][way] : 0;
         a = (a + 1 > CMAX) ? CMAX : a + 1;
         if (req_rb_miss) m = (m + 1 > CMAX) ? CMAX : m + 1;
         prom = (a >= int'(acc_thresh)) && (m >= int'(miss_thresh));
         if (m_val[s][way]) m_occ--;
         m_val[s][way] = !prom;
         if (!prom) m_occ++;
         m_tag[s][way] = t; m_acc[s][way] = a; m_miss[s][way] = m;
         touch(s, way);
         if (prom) begin m_mig = 1'b1; m_row = row; end
      end
      m_q = tick ? 0 : m_q + 1;
      m_ready = 1'b1;
   endtask

   task automatic check(string rq, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check(tag, "req_ready", int'(req_ready), int'(m_ready));
      check(tag, "mig_valid", int'(mig_valid), int'(m_mig));
      if (m_mig) check(tag, "mig_row", int'(mig_row), m_row);
      check(tag, "occ_count", int'(occ_count), m_occ);
      check(tag, "q_tick", int'(q_tick), int'(m_q == QUANTUM - 1));
   endtask

   task automatic step(bit v, int row, int off, bit miss);
      req_valid = v;
      req_addr = ADDR_W'(row * ROW_BYTES + off);
      req_rb_miss = miss;
      @(posedge clk);
      model_step();
      #1;
      compare_all();
   endtask

   task automatic to_quantum_start();
      while (m_q != 0) step(1'b0, 0, 0, 1'b0);
   endtask

   initial begin
      model_reset();
      #1;
      // R11: reset state
      for (int i = 0; i < 3; i++) step(1'b0, 0, 0, 1'b0);
      check("R11", "reset mig_valid", int'(mig_valid), 0);
      check("R11", "reset occ_count", int'(occ_count), 0);
      check("R11", "reset req_ready", int'(req_ready), 0);
      rst = 1'b0;
      tag = "R10";
      step(1'b0, 0, 0, 1'b0);
      check("R10", "ready after reset", int'(req_ready), 1);

      // R2 / R3: promotion needs both counts
      tag = "R3";
      to_quantum_start();
      acc_thresh = 3'd3; miss_thresh = 3'd2;
      step(1'b1, 100, 0, 1'b0);
      step(1'b1, 100, 8, 1'b1);
      step(1'b1, 100, 16, 1'b0);
      check("R2", "no promote at acc3 miss1", int'(mig_valid), 0);
      step(1'b1, 100, 24, 1'b1);
      check("R3", "promote at acc4 miss2", int'(mig_valid), 1);
      check("R3", "promoted row", int'(mig_row), 100);
      step(1'b0, 0, 0, 1'b0);
      check("R3", "strobe one cycle", int'(mig_valid), 0);

      // R1: offsets inside one 2 KB row share an entry
      tag = "R1";
      acc_thresh = 3'd2; miss_thresh = 3'd0;
      step(1'b1, 120, 5, 1'b0);
      step(1'b1, 120, 2047, 1'b0);
      check("R1", "same row promoted", int'(mig_valid), 1);
      check("R1", "row number", int'(mig_row), 120);

      // R4 / R7: hit-only row never promoted; counts saturate
      tag = "R4";
      to_quantum_start();
      acc_thresh = 3'd7; miss_thresh = 3'd1;
      for (int i = 0; i < 10; i++) begin
         step(1'b1, 300, 0, 1'b0);
         check("R4", "hit-only row quiet", int'(mig_valid), 0);
      end
      tag = "R7";
      step(1'b1, 300, 0, 1'b1);
      check("R7", "saturated access count promotes", int'(mig_valid), 1);

      // R8: entry removed after promotion
      tag = "R8";
      acc_thresh = 3'd2; miss_thresh = 3'd0;
      step(1'b1, 300, 0, 1'b0);
      check("R8", "fresh entry after promote", int'(mig_valid), 0);
      step(1'b1, 300, 0, 1'b0);
      check("R8", "second access promotes", int'(mig_valid), 1);

      // R6: set conflict, lowest empty way then least recently used way
      tag = "R6";
      to_quantum_start();
      acc_thresh = 3'd7; miss_thresh = 3'd7;
      for (int k = 0; k < 8; k++) step(1'b1, 5 + k * SETS, 0, 1'b0);
      check("R9", "eight entries", int'(occ_count), 8);
      step(1'b1, 5, 0, 1'b0);
      step(1'b1, 5 + 8 * SETS, 0, 1'b0);
      check("R6", "full set evicts", int'(occ_count), 8);
      acc_thresh = 3'd3; miss_thresh = 3'd0;
      step(1'b1, 5, 0, 1'b0);
      check("R6", "recent row kept", int'(mig_valid), 1);
      step(1'b1, 5 + SETS, 0, 1'b0);
      check("R6", "oldest row evicted", int'(mig_valid), 0);

      // R5: request in the tick cycle is counted after the clear
      tag = "R5";
      to_quantum_start();
      acc_thresh = 3'd3; miss_thresh = 3'd0;
      step(1'b1, 400, 0, 1'b0);
      step(1'b1, 400, 0, 1'b0);
      while (m_q != QUANTUM - 1) step(1'b0, 0, 0, 1'b0);
      check("R5", "tick visible", int'(q_tick), 1);
      step(1'b1, 400, 0, 1'b0);
      check("R5", "counts restarted", int'(mig_valid), 0);
      check("R5", "single entry after clear", int'(occ_count), 1);
      step(1'b1, 400, 0, 1'b0);
      step(1'b1, 400, 0, 1'b0);
      check("R5", "third access after clear promotes", int'(mig_valid), 1);

      // R10 / R9: back-to-back mixed traffic against the reference
      tag = "R9";
      for (int i = 0; i < 3000; i++) begin
         if (i % 300 == 0) begin
            acc_thresh = CNT_W'($urandom_range(1, 7));
            miss_thresh = CNT_W'($urandom_range(0, 4));
         end
         step(($urandom % 4) != 0, ($urandom % 16) * 37 + 2, $urandom % 2048, $urandom % 2);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule